// File: doc/BRIEF.md
# Glitch-Free Card Clock Generator

This block produces the clock for a smart card interface. It uses two clock inputs: a main clock and an asynchronous auxiliary clock. A programmable prescaler divides the main clock to make a converter clock. The prescaler uses a non-linear code: code 0 passes the main clock through, and codes 1 to 6 divide by twice the code. A source selector picks one of eight candidate clocks and drives it onto the card clock:

- the main clock, undivided or divided by 2 or 4;
- the converter clock, undivided or divided by 2 or 4;
- the auxiliary clock, undivided or divided by 2.

Software writes a single configuration byte with a strobe. This write must follow three rules:

- A move between the auxiliary pair and the other six sources is accepted only while the card clock is stopped.
- Entering the auxiliary pair takes two writes, one to each of its members.
- A prescaler code of 0 is legal only when an auxiliary source is in use.

A write that breaks a rule is dropped and raises a sticky error flag. The next accepted write clears that flag. Each source has its own enable, which is synchronized on that source's falling edge. When the selection changes, the old source is released before the new source is taken up, so the card clock never shows a shortened pulse. A stop request releases every source and holds the card clock low.

Top module: `scc_card_clk_gen`

## Requirements
- R1: After reset, the prescaler code is 1, so the converter clock is the main clock divided by 2. After reset, the active source code is 0 (main clock), and the error flag is clear.
- R2: Configuration bits 6:4 hold the prescaler code. Code 0 makes the converter clock follow the main clock. Codes 1 to 6 make it run at the main clock divided by 2, 4, 6, 8, 10 and 12.
- R3: At every even ratio, the converter clock has equal high and low times, each being ratio/2 main clock cycles.
- R4: Configuration bits 2:0 hold the source code, with this mapping:

  | Code | Card clock source |
  |------|-------------------|
  | 0 | main clock |
  | 1 | converter clock |
  | 2 | converter clock / 2 |
  | 3 | converter clock / 4 |
  | 4 | auxiliary clock |
  | 5 | auxiliary clock / 2 |
  | 6 | main clock / 2 |
  | 7 | main clock / 4 |

- R5: No pulse on the card clock is ever shorter than half a main clock period, including during a change of source. At most one source enable is active at any time.
- R6: While the clock-stop input is high, the card clock settles low and stays low.
- R7: A write that moves between the auxiliary pair {4,5} and the other codes while the clock-stop input is low is ignored and sets the error flag.
- R8: A write that would leave prescaler code 0 together with a non-auxiliary source is ignored and sets the error flag.
- R9: From a non-auxiliary source, the first write of code 4 or 5 only arms the pair and leaves the active source unchanged. Repeating the same code also leaves the active source unchanged. A following write of the other member of the pair makes that member active.
- R10: The error flag stays set until the next accepted write, which clears it.
- R11: Bits 7 and 3 of the configuration byte have no effect. Prescaler code 7 is rejected and sets the error flag.
- R12: The selection output always reports the active source code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock; also clocks the configuration logic |
| aux_clk | input | 1 | Auxiliary clock, asynchronous to clk |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wdata | input | 8 | Configuration byte |
| cfg_wr | input | 1 | One-cycle write strobe for cfg_wdata |
| clk_stop | input | 1 | Stops the card clock (held low) while high |
| card_clk | output | 1 | Selected card clock |
| conv_clk | output | 1 | Prescaled converter clock |
| active_sel | output | 3 | Source code currently active |
| sel_err | output | 1 | Sticky flag for the last rejected write |

## Verification
The assertions take for granted that the two strobe-side inputs, cfg_wr and clk_stop, change only in step with clk. They also take for granted that both clocks keep running, because a stalled source could never release its enable. The stimulus drives every input on the falling edge of clk. The auxiliary clock runs free and asynchronous throughout. Between any change of source and each edge count or pulse measurement, the stimulus waits longer than two periods of the slowest source.

// File: rtl/scc_pkg.sv
package scc_pkg;
    localparam int CODE_W  = 3;
    localparam int NUM_SRC = 1 << CODE_W;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t PRE_RESET  = 3'd1;
    localparam code_t PRE_RSVD   = 3'd7;
    localparam code_t PRE_BYPASS = 3'd0;
    localparam code_t SRC_RESET  = 3'd0;
    localparam code_t SRC_AUX    = 3'd4;
    localparam code_t SRC_AUX_D2 = 3'd5;

    typedef struct packed {
        code_t pre;
        code_t active;
        logic  armed;
        code_t arm_code;
        logic  err;
    } cfg_state_t;

    function automatic logic is_aux(input code_t c);
        return (c == SRC_AUX) || (c == SRC_AUX_D2);
    endfunction
endpackage

// File: rtl/scc_cfg_ctrl.sv
module scc_cfg_ctrl
    import scc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr,
    input  code_t wr_pre,
    input  code_t wr_src,
    input  logic  stop,
    output code_t pre,
    output code_t active,
    output logic  err
);
    cfg_state_t state_d, state_q;
    logic wr_aux, cur_aux, completes, ends_aux, bad;

    always_comb begin
        state_d   = state_q;
        wr_aux    = is_aux(wr_src);
        cur_aux   = is_aux(state_q.active);
        completes = state_q.armed && wr_aux && (wr_src != state_q.arm_code);
        ends_aux  = wr_aux && (cur_aux || completes);
        bad       = (wr_pre == PRE_RSVD)
                 || ((wr_aux != cur_aux) && !stop)
                 || ((wr_pre == PRE_BYPASS) && !ends_aux);
        if (wr) begin
            if (bad) begin
                state_d.err = 1'b1;
            end else begin
                state_d.err = 1'b0;
                state_d.pre = wr_pre;
                if (!wr_aux || cur_aux || completes) begin
                    state_d.active = wr_src;
                    state_d.armed  = 1'b0;
                end else begin
                    state_d.armed    = 1'b1;
                    state_d.arm_code = wr_src;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{pre: PRE_RESET, active: SRC_RESET, armed: 1'b0,
                         arm_code: SRC_RESET, err: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign pre    = state_q.pre;
    assign active = state_q.active;
    assign err    = state_q.err;

    p_cross_needs_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !stop && (is_aux(wr_src) != is_aux(active))
        |=> err && $stable(active) && $stable(pre));

    p_bypass_rejected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr && (wr_pre == PRE_BYPASS) && !is_aux(wr_src)
        |=> err && $stable(active) && $stable(pre));

    p_bypass_only_aux_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pre == PRE_BYPASS) |-> is_aux(active));

    p_rsvd_prescale_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr && (wr_pre == PRE_RSVD) |=> err && $stable(pre));

    p_first_aux_arms_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !state_q.armed && !is_aux(active) && is_aux(wr_src)
        |=> $stable(active));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(err));
endmodule

// File: rtl/scc_conv_div.sv
module scc_conv_div #(
    parameter int CODE_W = 3,
    localparam int CNT_W = CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic              conv_clk
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tgl;
    } div_state_t;

    div_state_t div_d, div_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        div_d = div_q;
        last  = code - CNT_W'(1);
        if (code == '0) begin
            div_d.cnt = '0;
            div_d.tgl = 1'b0;
        end else if (div_q.cnt >= last) begin
            div_d.cnt = '0;
            div_d.tgl = ~div_q.tgl;
        end else begin
            div_d.cnt = div_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign conv_clk = (code == '0) ? clk : div_q.tgl;

    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (code != '0) && ($past(code) == code) && ($past(code, 2) == code)
        |-> div_q.cnt < code);

    p_bypass_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (code == '0) |=> (div_q.cnt == '0) && !div_q.tgl);
endmodule

// File: rtl/scc_div_pow2.sv
module scc_div_pow2 #(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES-1:0] taps
);
    logic [STAGES-1:0] cnt_d, cnt_q;

    always_comb cnt_d = cnt_q + STAGES'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign taps = cnt_q;
endmodule

// File: rtl/scc_gf_mux.sv
module scc_gf_mux #(
    parameter int N           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         rst_n,
    input  logic [N-1:0] src,
    input  logic [N-1:0] sel_oh,
    input  logic         stop,
    output logic [N-1:0] en,
    output logic         card_clk
);
    logic [N-1:0] en_req;

    for (genvar g = 0; g < N; g++) begin : g_src
        localparam logic [N-1:0] OTHERS = ~(N'(1) << g);
        logic [SYNC_STAGES-1:0] sh_d, sh_q;

        always_comb begin
            en_req[g] = sel_oh[g] && !stop && !(|(en & OTHERS));
            sh_d      = {sh_q[SYNC_STAGES-2:0], en_req[g]};
        end

        always_ff @(negedge src[g] or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign en[g] = sh_q[SYNC_STAGES-1];
    end

    assign card_clk = |(src & en);
endmodule

// File: rtl/scc_card_clk_gen.sv
module scc_card_clk_gen
    import scc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        aux_clk,
    input  logic        rst_n,
    input  logic [7:0]  cfg_wdata,
    input  logic        cfg_wr,
    input  logic        clk_stop,
    output logic        card_clk,
    output logic        conv_clk,
    output logic [2:0]  active_sel,
    output logic        sel_err
);
    localparam int PRE_LSB = 4;
    localparam int SRC_LSB = 0;

    code_t pre, active;
    logic [1:0] clk_taps, conv_taps;
    logic [0:0] aux_taps;
    logic [NUM_SRC-1:0] src, sel_oh, en;

    scc_cfg_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .wr_pre (cfg_wdata[PRE_LSB +: CODE_W]),
        .wr_src (cfg_wdata[SRC_LSB +: CODE_W]),
        .stop   (clk_stop),
        .pre    (pre),
        .active (active),
        .err    (sel_err)
    );

    scc_conv_div #(.CODE_W(CODE_W)) u_conv (
        .clk      (clk),
        .rst_n    (rst_n),
        .code     (pre),
        .conv_clk (conv_clk)
    );

    scc_div_pow2 #(.STAGES(2)) u_clk_div  (.clk(clk),      .rst_n(rst_n), .taps(clk_taps));
    scc_div_pow2 #(.STAGES(2)) u_conv_div (.clk(conv_clk), .rst_n(rst_n), .taps(conv_taps));
    scc_div_pow2 #(.STAGES(1)) u_aux_div  (.clk(aux_clk),  .rst_n(rst_n), .taps(aux_taps));

    assign src = {clk_taps[1], clk_taps[0], aux_taps[0], aux_clk,
                  conv_taps[1], conv_taps[0], conv_clk, clk};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_dec
        assign sel_oh[g] = (active == code_t'(g));
    end

    scc_gf_mux #(.N(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_mux (
        .rst_n    (rst_n),
        .src      (src),
        .sel_oh   (sel_oh),
        .stop     (clk_stop),
        .en       (en),
        .card_clk (card_clk)
    );

    assign active_sel = active;

    p_single_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en));

    p_rsvd_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && (cfg_wdata[7] || cfg_wdata[3])
        && (cfg_wdata[6:4] != PRE_RSVD) && (cfg_wdata[6:4] != PRE_BYPASS)
        && !is_aux(cfg_wdata[2:0]) && !is_aux(active_sel)
        |=> !sel_err && (active_sel == $past(cfg_wdata[2:0])));
endmodule

// File: tb/scc_card_clk_gen_bench.sv
`timescale 1ns/1ps
module scc_card_clk_gen_bench;
    logic clk = 1'b0, aux_clk = 1'b0, rst_n = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic cfg_wr = 1'b0, clk_stop = 1'b0;
    logic card_clk, conv_clk, sel_err;
    logic [2:0] active_sel;

    int checks = 0, failures = 0;
    int card_edges = 0, conv_edges = 0;
    bit done = 1'b0;
    realtime last_t = -1.0, min_w = 1.0e9;

    always #2 clk = ~clk;
    initial begin
        #3;
        forever #8 aux_clk = ~aux_clk;
    end

    scc_card_clk_gen u_scc_card_clk_gen (
        .clk(clk), .aux_clk(aux_clk), .rst_n(rst_n), .cfg_wdata(cfg_wdata),
        .cfg_wr(cfg_wr), .clk_stop(clk_stop), .card_clk(card_clk),
        .conv_clk(conv_clk), .active_sel(active_sel), .sel_err(sel_err)
    );

    always @(posedge card_clk) card_edges++;
    always @(posedge conv_clk) conv_edges++;
    always @(card_clk) begin
        if (rst_n && last_t >= 0.0 && ($realtime - last_t) < min_w)
            min_w = $realtime - last_t;
        last_t = $realtime;
    end

    // {wdata[7:0], stop, exp_sel[2:0], exp_err, exp_edges[7:0]} ; edges over 64 main cycles
    localparam int NV = 23;
    localparam logic [20:0] VEC [NV] = '{
        {8'h16, 1'b0, 3'd6, 1'b0, 8'd32},  // R4 main/2
        {8'h17, 1'b0, 3'd7, 1'b0, 8'd16},  // R4 main/4
        {8'h11, 1'b0, 3'd1, 1'b0, 8'd32},  // R4 conv, ratio 2
        {8'h12, 1'b0, 3'd2, 1'b0, 8'd16},  // R4 conv/2
        {8'h13, 1'b0, 3'd3, 1'b0, 8'd8},   // R4 conv/4
        {8'h23, 1'b0, 3'd3, 1'b0, 8'd4},   // R2 ratio 4, conv/4
        {8'h21, 1'b0, 3'd1, 1'b0, 8'd16},  // R2 ratio 4
        {8'h61, 1'b0, 3'd1, 1'b0, 8'd5},   // R2 ratio 12
        {8'h31, 1'b0, 3'd1, 1'b0, 8'd11},  // R2 ratio 6
        {8'h14, 1'b0, 3'd1, 1'b1, 8'd11},  // R7 crossing while running
        {8'h9E, 1'b0, 3'd6, 1'b0, 8'd32},  // R11 reserved bits, R10 clear
        {8'h06, 1'b0, 3'd6, 1'b1, 8'd32},  // R8 bypass with main source
        {8'h76, 1'b0, 3'd6, 1'b1, 8'd32},  // R11 prescaler code 7
        {8'h14, 1'b1, 3'd6, 1'b0, 8'd32},  // R9 first aux write arms only
        {8'h15, 1'b1, 3'd5, 1'b0, 8'd8},   // R9 second write switches
        {8'h14, 1'b0, 3'd4, 1'b0, 8'd16},  // R4 aux within pair
        {8'h04, 1'b0, 3'd4, 1'b0, 8'd16},  // R8 bypass allowed on aux
        {8'h10, 1'b0, 3'd4, 1'b1, 8'd16},  // R7 leaving pair while running
        {8'h10, 1'b1, 3'd0, 1'b0, 8'd64},  // R4 main clock, leaving while stopped
        {8'h15, 1'b1, 3'd0, 1'b0, 8'd64},  // R9 arm
        {8'h15, 1'b1, 3'd0, 1'b0, 8'd64},  // R9 same code again
        {8'h14, 1'b1, 3'd4, 1'b0, 8'd16},  // R9 other member
        {8'h11, 1'b1, 3'd1, 1'b0, 8'd32}   // R4 back to conv while stopped
    };

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_wdata = v;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic count_card(output int n);
        int e0;
        e0 = card_edges;
        repeat (64) @(negedge clk);
        n = card_edges - e0;
    endtask

    task automatic count_conv(output int n);
        int e0;
        e0 = conv_edges;
        repeat (64) @(negedge clk);
        n = conv_edges - e0;
    endtask

    task automatic near(input int act, input int exp, input string what);
        chk((act >= exp - 1) && (act <= exp + 1), what, act, exp);
    endtask

    task automatic duty(input int half_ps, input string what);
        realtime t0, t1, t2;
        @(posedge conv_clk); t0 = $realtime;
        @(negedge conv_clk); t1 = $realtime;
        @(posedge conv_clk); t2 = $realtime;
        chk(int'((t1 - t0) * 1000.0) == half_ps, {what, " high"}, int'((t1 - t0) * 1000.0), half_ps);
        chk(int'((t2 - t1) * 1000.0) == half_ps, {what, " low"}, int'((t2 - t1) * 1000.0), half_ps);
    endtask

    task automatic report;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        int n;
        logic [20:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        // R1 reset state
        chk(active_sel == 3'd0, "R1 reset selection", active_sel, 0);
        chk(sel_err == 1'b0, "R1 reset error flag", sel_err, 0);
        count_conv(n); near(n, 32, "R1 reset prescaler ratio 2");
        count_card(n); near(n, 64, "R1 reset card clock = main");

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            clk_stop = v[12];
            repeat (8) @(negedge clk);
            cfg_write(v[20:13]);
            repeat (8) @(negedge clk);
            chk(active_sel == v[11:9], $sformatf("R12 vec %0d selection", i), active_sel, v[11:9]);
            chk(sel_err == v[8], $sformatf("R7/R8/R10 vec %0d error flag", i), sel_err, v[8]);
            clk_stop = 1'b0;
            repeat (300) @(negedge clk);
            count_card(n);
            near(n, v[7:0], $sformatf("R4 vec %0d card edges", i));
        end

        // R2/R3 converter ratios and duty
        cfg_write(8'h31);
        repeat (40) @(negedge clk);
        count_conv(n); near(n, 11, "R2 ratio 6 conv edges");
        duty(12000, "R3 ratio 6");
        cfg_write(8'h61);
        repeat (40) @(negedge clk);
        duty(24000, "R3 ratio 12");

        // R6 stop holds the card clock low
        clk_stop = 1'b1;
        repeat (300) @(negedge clk);
        count_card(n);
        chk(n == 0, "R6 no edges while stopped", n, 0);
        chk(card_clk == 1'b0, "R6 card clock low", card_clk, 0);
        clk_stop = 1'b0;

        // R1 reset mid-run, then R9 arming after reset
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        chk(active_sel == 3'd0, "R1 selection after reset", active_sel, 0);
        count_conv(n); near(n, 32, "R1 ratio 2 after reset");
        clk_stop = 1'b1;
        cfg_write(8'h14);
        repeat (8) @(negedge clk);
        chk(active_sel == 3'd0, "R9 first aux write after reset", active_sel, 0);
        clk_stop = 1'b0;
        repeat (300) @(negedge clk);
        count_card(n); near(n, 64, "R9 main clock kept after arming");

        // R5 no runt pulse anywhere in the run
        chk(min_w >= 1.9, "R5 shortest card pulse (ps)", int'(min_w * 1000.0), 2000);
        done = 1'b1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            report();
        end
    end
endmodule